// File: doc/BRIEF.md
# Paged External Data RAM

This block holds a 512-byte data RAM that sits in a 16-bit external data address space. Two requesters can reach it. The wide port carries a full 16-bit pointer. Only the low nine bits of that pointer select a byte, so the RAM repeats every 512 bytes across the whole 64K range. The short port carries an 8-bit register-indirect address. The byte above it comes from a one-bit page register.

The page register sits on a special-function-register bus at address 0xAA. Only bit 0 exists. The upper seven bits always read back as zero, and writes to them are dropped.

RAM writes are synchronous. Read data is registered and appears one cycle after the read strobe. It then holds until the next read. When both ports request in the same cycle, the wide port wins and the short request is dropped.

Top module: `xdata_paged_ram`

## Requirements
- R1: Synchronous reset (rst high at a clock edge) clears the page bit to 0, `mem_rdata` to 0x00 and `sfr_rdata` to 0x00.
- R2: A wide-port access reaches physical byte `wide_addr[8:0]`. Bits 15..9 are ignored, so a byte written at address A reads back at A + k*0x200 for any k.
- R3: A short-port access reaches physical byte `{page, short_addr[7:0]}`. Page 0 covers bytes 0x000..0x0FF and page 1 covers bytes 0x100..0x1FF.
- R4: An SFR write with `sfr_addr` = 0xAA loads the page bit from `sfr_wdata[0]`. An SFR read at 0xAA returns `{7'b0, page}` on `sfr_rdata` one cycle later, so bits 7..1 always read as zero.
- R5: An SFR read at any address other than 0xAA returns 0x00 one cycle later. An SFR write at any other address leaves the page bit unchanged.
- R6: A page write takes effect on its own clock edge, so a short-port access in the very next cycle already uses the new page.
- R7: A RAM write takes effect at the edge where its write strobe is high. `mem_rdata` shows the addressed byte one cycle after a read strobe and holds its value in cycles with no read. A read and a write on the same port in the same cycle return the old byte.
- R8: When any wide strobe is high, every short-port strobe in that cycle is ignored. A short write in that cycle does not change the RAM, and a simultaneous read returns the wide-port byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wide_rd_en | input | 1 | Wide-port read strobe |
| wide_wr_en | input | 1 | Wide-port write strobe |
| wide_addr | input | 16 | Wide-port 16-bit pointer address |
| wide_wdata | input | 8 | Wide-port write data |
| short_rd_en | input | 1 | Short-port read strobe |
| short_wr_en | input | 1 | Short-port write strobe |
| short_addr | input | 8 | Short-port 8-bit indirect address |
| short_wdata | input | 8 | Short-port write data |
| mem_rdata | output | 8 | Registered RAM read data |
| sfr_addr | input | 8 | SFR bus address |
| sfr_wr_en | input | 1 | SFR write strobe |
| sfr_wdata | input | 8 | SFR write data |
| sfr_rd_en | input | 1 | SFR read strobe |
| sfr_rdata | output | 8 | Registered SFR read data |

## Verification
The bench fills all 512 bytes through one alias of the wide port and reads every byte back through another alias. A design that kept a high address bit would fail both the aliasing checks and the readback. It then sweeps the short port over both pages, which catches a page bit that is ignored or lands in the wrong position. It also checks the page in the cycle right after the page write, which exposes a page that is applied a cycle late.

The SFR checks write all ones, then 0xFE, then target a neighbouring address. A design that decodes the address loosely, or stores or returns the upper bits, shows the wrong readback. A final phase issues a wide access and a short access in the same cycle. A design with the wrong priority would corrupt the short-port byte or return the wrong read data.

// File: rtl/xdram_pkg.sv
package xdram_pkg;
  localparam int unsigned RAM_BYTES    = 512;
  localparam int unsigned BYTE_W       = 8;
  localparam int unsigned PTR_W        = 16;
  localparam int unsigned IND_W        = 8;
  localparam int unsigned SFR_A_W      = 8;
  localparam int unsigned SFR_D_W      = 8;
  localparam logic [7:0]  PAGE_SFR_LOC = 8'hAA;

  typedef enum logic [1:0] {
    SRC_IDLE  = 2'd0,
    SRC_WIDE  = 2'd1,
    SRC_SHORT = 2'd2
  } src_e;
endpackage

// File: rtl/xdram_page_reg.sv
module xdram_page_reg #(
  parameter int unsigned SFR_A_W = 8,
  parameter int unsigned SFR_D_W = 8,
  parameter int unsigned PAGE_W  = 1,
  parameter logic [SFR_A_W-1:0] REG_LOC = 8'hAA
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [SFR_A_W-1:0] sfr_addr,
  input  logic               sfr_wr_en,
  input  logic [SFR_D_W-1:0] sfr_wdata,
  input  logic               sfr_rd_en,
  output logic [SFR_D_W-1:0] sfr_rdata,
  output logic [PAGE_W-1:0]  page
);
  localparam logic [SFR_D_W-1:0] PAGE_MOD = SFR_D_W'(1 << PAGE_W);

  logic hit;
  logic [PAGE_W-1:0] page_q;
  logic [SFR_D_W-1:0] rdata_q;

  assign hit = (sfr_addr == REG_LOC);

  always_ff @(posedge clk) begin
    if (rst) begin
      page_q <= '0;
    end else if (sfr_wr_en && hit) begin
      page_q <= PAGE_W'(sfr_wdata % PAGE_MOD);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else if (sfr_rd_en && hit) begin
      rdata_q <= {{(SFR_D_W-PAGE_W){1'b0}}, page_q};
    end else begin
      rdata_q <= '0;
    end
  end

  assign page      = page_q;
  assign sfr_rdata = rdata_q;
endmodule

// File: rtl/xdram_addr_mux.sv
module xdram_addr_mux
  import xdram_pkg::*;
#(
  parameter int unsigned PTR_W  = 16,
  parameter int unsigned IND_W  = 8,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned IDX_W  = 9,
  parameter int unsigned PAGE_W = 1
) (
  input  logic              wide_rd_en,
  input  logic              wide_wr_en,
  input  logic [PTR_W-1:0]  wide_addr,
  input  logic [DATA_W-1:0] wide_wdata,
  input  logic              short_rd_en,
  input  logic              short_wr_en,
  input  logic [IND_W-1:0]  short_addr,
  input  logic [DATA_W-1:0] short_wdata,
  input  logic [PAGE_W-1:0] page,
  output src_e              src,
  output logic              ram_we,
  output logic              ram_re,
  output logic [IDX_W-1:0]  ram_idx,
  output logic [DATA_W-1:0] ram_wdata
);
  localparam logic [PTR_W-1:0] WRAP = PTR_W'(1 << IDX_W);

  logic [IDX_W-1:0] wide_idx;
  logic [IDX_W-1:0] short_idx;

  // modulo wrap: the pointer bits above the RAM index do not matter
  assign wide_idx  = IDX_W'(wide_addr % WRAP);
  assign short_idx = {page, short_addr};

  always_comb begin
    src       = SRC_IDLE;
    ram_we    = 1'b0;
    ram_re    = 1'b0;
    ram_idx   = short_idx;
    ram_wdata = short_wdata;
    if (wide_rd_en || wide_wr_en) begin
      src       = SRC_WIDE;
      ram_we    = wide_wr_en;
      ram_re    = wide_rd_en;
      ram_idx   = wide_idx;
      ram_wdata = wide_wdata;
    end else if (short_rd_en || short_wr_en) begin
      src       = SRC_SHORT;
      ram_we    = short_wr_en;
      ram_re    = short_rd_en;
    end
  end
endmodule

// File: rtl/xdram_array.sv
module xdram_array #(
  parameter int unsigned DEPTH  = 512,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned IDX_W  = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic              re,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] rdata_q;

  always_ff @(posedge clk) begin
    if (we) begin
      mem[idx] <= wdata;
    end
  end

  // read-first output register with synchronous reset
  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else if (re) begin
      rdata_q <= mem[idx];
    end
  end

  assign rdata = rdata_q;
endmodule

// File: rtl/xdata_paged_ram.sv
module xdata_paged_ram
  import xdram_pkg::*;
#(
  parameter int unsigned DEPTH    = RAM_BYTES,
  parameter int unsigned DATA_W   = BYTE_W,
  parameter int unsigned ADDR_W   = PTR_W,
  parameter int unsigned SHORT_W  = IND_W,
  parameter int unsigned SA_W     = SFR_A_W,
  parameter int unsigned SD_W     = SFR_D_W,
  parameter logic [SA_W-1:0] PAGE_LOC = PAGE_SFR_LOC
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wide_rd_en,
  input  logic               wide_wr_en,
  input  logic [ADDR_W-1:0]  wide_addr,
  input  logic [DATA_W-1:0]  wide_wdata,
  input  logic               short_rd_en,
  input  logic               short_wr_en,
  input  logic [SHORT_W-1:0] short_addr,
  input  logic [DATA_W-1:0]  short_wdata,
  output logic [DATA_W-1:0]  mem_rdata,
  input  logic [SA_W-1:0]    sfr_addr,
  input  logic               sfr_wr_en,
  input  logic [SD_W-1:0]    sfr_wdata,
  input  logic               sfr_rd_en,
  output logic [SD_W-1:0]    sfr_rdata
);
  localparam int unsigned IDX_W  = $clog2(DEPTH);
  localparam int unsigned PAGE_W = IDX_W - SHORT_W;

  logic [PAGE_W-1:0] page_q;
  src_e              src;
  logic              ram_we;
  logic              ram_re;
  logic [IDX_W-1:0]  ram_idx;
  logic [DATA_W-1:0] ram_wdata;

  xdram_page_reg #(
    .SFR_A_W(SA_W), .SFR_D_W(SD_W), .PAGE_W(PAGE_W), .REG_LOC(PAGE_LOC)
  ) u_page (
    .clk(clk), .rst(rst),
    .sfr_addr(sfr_addr), .sfr_wr_en(sfr_wr_en), .sfr_wdata(sfr_wdata),
    .sfr_rd_en(sfr_rd_en), .sfr_rdata(sfr_rdata),
    .page(page_q)
  );

  xdram_addr_mux #(
    .PTR_W(ADDR_W), .IND_W(SHORT_W), .DATA_W(DATA_W), .IDX_W(IDX_W), .PAGE_W(PAGE_W)
  ) u_mux (
    .wide_rd_en(wide_rd_en), .wide_wr_en(wide_wr_en),
    .wide_addr(wide_addr), .wide_wdata(wide_wdata),
    .short_rd_en(short_rd_en), .short_wr_en(short_wr_en),
    .short_addr(short_addr), .short_wdata(short_wdata),
    .page(page_q), .src(src),
    .ram_we(ram_we), .ram_re(ram_re), .ram_idx(ram_idx), .ram_wdata(ram_wdata)
  );

  xdram_array #(
    .DEPTH(DEPTH), .DATA_W(DATA_W), .IDX_W(IDX_W)
  ) u_ram (
    .clk(clk), .rst(rst),
    .we(ram_we), .re(ram_re), .idx(ram_idx), .wdata(ram_wdata),
    .rdata(mem_rdata)
  );
endmodule

// File: rtl/xdram_chk.sv
module xdram_chk
  import xdram_pkg::*;
#(
  parameter int unsigned ADDR_W  = 16,
  parameter int unsigned SHORT_W = 8,
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned IDX_W   = 9,
  parameter int unsigned PAGE_W  = 1,
  parameter int unsigned SA_W    = 8,
  parameter int unsigned SD_W    = 8,
  parameter logic [SA_W-1:0] PAGE_LOC = 8'hAA
) (
  input logic               clk,
  input logic               rst,
  input logic               wide_rd_en,
  input logic               wide_wr_en,
  input logic [ADDR_W-1:0]  wide_addr,
  input logic               short_rd_en,
  input logic               short_wr_en,
  input logic [SHORT_W-1:0] short_addr,
  input logic [DATA_W-1:0]  mem_rdata,
  input logic [SA_W-1:0]    sfr_addr,
  input logic               sfr_wr_en,
  input logic [SD_W-1:0]    sfr_wdata,
  input logic               sfr_rd_en,
  input logic [SD_W-1:0]    sfr_rdata,
  input logic [PAGE_W-1:0]  page_q,
  input src_e               src,
  input logic               ram_we,
  input logic [IDX_W-1:0]   ram_idx
);
  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (page_q == '0 && mem_rdata == '0 && sfr_rdata == '0));

  // R2
  wide_alias_chk: assert property (@(posedge clk) disable iff (rst)
    (wide_rd_en || wide_wr_en) |-> (ram_idx == wide_addr[IDX_W-1:0] && src == SRC_WIDE));

  // R3
  short_page_chk: assert property (@(posedge clk) disable iff (rst)
    ((short_rd_en || short_wr_en) && !wide_rd_en && !wide_wr_en)
      |-> (ram_idx == {page_q, short_addr} && ram_we == short_wr_en));

  // R4
  page_load_chk: assert property (@(posedge clk) disable iff (rst)
    (sfr_wr_en && sfr_addr == PAGE_LOC) |=> (page_q == $past(sfr_wdata[PAGE_W-1:0])));

  // R4
  upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
    sfr_rd_en |=> (sfr_rdata[SD_W-1:PAGE_W] == '0));

  // R5
  page_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(sfr_wr_en && sfr_addr == PAGE_LOC) |=> $stable(page_q));

  // R5
  foreign_read_chk: assert property (@(posedge clk) disable iff (rst)
    (sfr_rd_en && sfr_addr != PAGE_LOC) |=> (sfr_rdata == '0));

  // R7
  rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!wide_rd_en && !short_rd_en) |=> $stable(mem_rdata));

  // R8
  wide_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (wide_rd_en || wide_wr_en) |-> (ram_we == wide_wr_en));
endmodule

bind xdata_paged_ram xdram_chk #(
  .ADDR_W(ADDR_W), .SHORT_W(SHORT_W), .DATA_W(DATA_W), .IDX_W(IDX_W),
  .PAGE_W(PAGE_W), .SA_W(SA_W), .SD_W(SD_W), .PAGE_LOC(PAGE_LOC)
) u_chk (
  .clk(clk), .rst(rst),
  .wide_rd_en(wide_rd_en), .wide_wr_en(wide_wr_en), .wide_addr(wide_addr),
  .short_rd_en(short_rd_en), .short_wr_en(short_wr_en), .short_addr(short_addr),
  .mem_rdata(mem_rdata),
  .sfr_addr(sfr_addr), .sfr_wr_en(sfr_wr_en), .sfr_wdata(sfr_wdata),
  .sfr_rd_en(sfr_rd_en), .sfr_rdata(sfr_rdata),
  .page_q(page_q), .src(src), .ram_we(ram_we), .ram_idx(ram_idx)
);

// File: tb/sim_xdata_paged_ram.sv
module sim_xdata_paged_ram;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wide_rd_en = 0, wide_wr_en = 0;
  logic [15:0] wide_addr = '0;
  logic [7:0]  wide_wdata = '0;
  logic        short_rd_en = 0, short_wr_en = 0;
  logic [7:0]  short_addr = '0, short_wdata = '0;
  logic [7:0]  mem_rdata;
  logic [7:0]  sfr_addr = '0, sfr_wdata = '0, sfr_rdata;
  logic        sfr_wr_en = 0, sfr_rd_en = 0;

  int checks = 0;
  int errors = 0;
  logic [7:0] model [512];

  always #2 clk = ~clk;

  xdata_paged_ram u0 (
    .clk(clk), .rst(rst),
    .wide_rd_en(wide_rd_en), .wide_wr_en(wide_wr_en),
    .wide_addr(wide_addr), .wide_wdata(wide_wdata),
    .short_rd_en(short_rd_en), .short_wr_en(short_wr_en),
    .short_addr(short_addr), .short_wdata(short_wdata),
    .mem_rdata(mem_rdata),
    .sfr_addr(sfr_addr), .sfr_wr_en(sfr_wr_en), .sfr_wdata(sfr_wdata),
    .sfr_rd_en(sfr_rd_en), .sfr_rdata(sfr_rdata)
  );

  function automatic logic [7:0] pat(int i, int salt);
    return 8'((i * 37 + salt) ^ (i >> 3));
  endfunction

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic idle();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic wide_wr(logic [15:0] a, logic [7:0] d);
    wide_wr_en = 1; wide_addr = a; wide_wdata = d;
    idle();
    wide_wr_en = 0;
  endtask

  task automatic wide_rd(logic [15:0] a);
    wide_rd_en = 1; wide_addr = a;
    idle();
    wide_rd_en = 0;
  endtask

  task automatic short_wr(logic [7:0] a, logic [7:0] d);
    short_wr_en = 1; short_addr = a; short_wdata = d;
    idle();
    short_wr_en = 0;
  endtask

  task automatic short_rd(logic [7:0] a);
    short_rd_en = 1; short_addr = a;
    idle();
    short_rd_en = 0;
  endtask

  task automatic sfr_wr(logic [7:0] a, logic [7:0] d);
    sfr_wr_en = 1; sfr_addr = a; sfr_wdata = d;
    idle();
    sfr_wr_en = 0;
  endtask

  task automatic sfr_rd(logic [7:0] a);
    sfr_rd_en = 1; sfr_addr = a;
    idle();
    sfr_rd_en = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk); idle(); idle();
    rst = 0;
    // R1 reset state
    chk("R1 mem_rdata", mem_rdata, 8'h00);
    chk("R1 sfr_rdata", sfr_rdata, 8'h00);
    sfr_rd(8'hAA);
    chk("R1 page reads 0", sfr_rdata, 8'h00);

    // R2 fill through one alias, read back through another
    for (int i = 0; i < 512; i++) begin
      model[i] = pat(i, 11);
      wide_wr(16'(i + 512 * (i % 128)), model[i]);
    end
    for (int i = 0; i < 512; i++) begin
      wide_rd(16'(i + 512 * (127 - (i % 128))));
      chk("R2 alias readback", mem_rdata, model[i]);
    end

    // R3 page 0 sweep
    for (int i = 0; i < 256; i++) begin
      short_rd(8'(i));
      chk("R3 page0", mem_rdata, model[i]);
    end
    // R4 write all ones: only bit 0 kept
    sfr_wr(8'hAA, 8'hFF);
    sfr_rd(8'hAA);
    chk("R4 readback 0xFF write", sfr_rdata, 8'h01);
    // R3 page 1 sweep and short-port writes
    for (int i = 0; i < 256; i++) begin
      model[256 + i] = pat(i, 99);
      short_wr(8'(i), model[256 + i]);
    end
    for (int i = 0; i < 512; i++) begin
      wide_rd(16'(i) | 16'hFE00);
      chk("R3 page1 write seen at wide", mem_rdata, model[i]);
    end

    // R5 foreign SFR address
    sfr_rd(8'hAB);
    chk("R5 foreign read", sfr_rdata, 8'h00);
    sfr_wr(8'hAB, 8'h00);
    sfr_wr(8'h2A, 8'h00);
    sfr_rd(8'hAA);
    chk("R5 page unchanged", sfr_rdata, 8'h01);

    // R4 write 0xFE clears page
    sfr_wr(8'hAA, 8'hFE);
    sfr_rd(8'hAA);
    chk("R4 readback 0xFE write", sfr_rdata, 8'h00);
    short_rd(8'h40);
    chk("R4 page cleared", mem_rdata, model[16'h040]);

    // R6 page change used in the very next cycle
    sfr_wr(8'hAA, 8'h01);
    short_rd(8'h10);
    chk("R6 new page next cycle", mem_rdata, model[16'h110]);
    sfr_wr(8'hAA, 8'h00);
    short_rd(8'h10);
    chk("R6 back to page0", mem_rdata, model[16'h010]);

    // R7 hold and read-first
    wide_rd(16'h0033);
    idle(); idle();
    chk("R7 hold idle", mem_rdata, model[16'h033]);
    wide_wr(16'h0034, 8'h5C);
    chk("R7 hold over write", mem_rdata, model[16'h033]);
    model[16'h034] = 8'h5C;
    wide_rd(16'h0034);
    chk("R7 write took effect", mem_rdata, 8'h5C);
    wide_rd_en = 1; wide_wr_en = 1; wide_addr = 16'h0035; wide_wdata = 8'hC3;
    idle();
    wide_rd_en = 0; wide_wr_en = 0;
    chk("R7 read-first", mem_rdata, model[16'h035]);
    model[16'h035] = 8'hC3;
    wide_rd(16'h0035);
    chk("R7 same-cycle write stored", mem_rdata, 8'hC3);

    // R8 wide wins over short
    wide_wr_en = 1; wide_addr = 16'h0070; wide_wdata = 8'hA7;
    short_wr_en = 1; short_addr = 8'h80; short_wdata = 8'h3E;
    idle();
    wide_wr_en = 0; short_wr_en = 0;
    model[16'h070] = 8'hA7;
    wide_rd(16'h0080);
    chk("R8 short write dropped", mem_rdata, model[16'h080]);
    wide_rd(16'h0070);
    chk("R8 wide write done", mem_rdata, 8'hA7);
    wide_rd_en = 1; wide_addr = 16'h0190;
    short_rd_en = 1; short_addr = 8'h20;
    idle();
    wide_rd_en = 0; short_rd_en = 0;
    chk("R8 wide read wins", mem_rdata, model[16'h190]);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule